// File: doc/BRIEF.md
# Transactional Overflow Directory Controller

This block is the home directory for a small region of memory blocks in an invalidation-based coherence protocol that supports hardware transactions. For each block it records a state, an owner and a full bit-vector of sharers. It serves read-shared (GETS), read-exclusive (GETX) and dirty-writeback (PUTX) requests from a few processors. When a transaction's working set no longer fits in a processor's cache, that processor writes the block back. The directory then keeps the entry pinned to the writer in a sticky-modified state and raises that processor's overflow bit, so later accesses by other processors are still sent to it for conflict detection.

A request that reaches a block owned by another processor, or a block in the sticky state, is forwarded to the recorded processor. That processor answers through a one-cycle answer strobe with NACK (conflict, so the requester retries), CLEAN (no conflict with a sticky entry) or DATA (an owned block is handed over). While a forward is outstanding, the affected block is locked and any other request that would need a forward is turned away with a busy code. A transaction end (commit or abort) clears only the processor's overflow bit. Sticky entries are cleaned later, when the next access reaches them and the old holder answers CLEAN.

Top module: `dir_top`

## Requirements
- R1: After reset every entry is invalid, all overflow bits are 0 and no output strobe is high. A GETS (op 0) or GETX (op 1) to an invalid or shared block is answered one cycle later on the response channel with GRANT_S (code 1) or GRANT_M (code 2). GETS adds the requester to the sharers. GETX makes the requester the sole owner.
- R2: A PUTX (op 2) from the owner of a modified block with the transaction flag set is answered with ACK (code 3). The entry becomes sticky-modified and keeps pointing at the writer. The writer's overflow bit (bit index = processor number) reads 1 one cycle after the request.
- R3: A GETS or GETX from a processor other than the recorded owner of a modified or sticky block produces no response. Instead, one cycle later it produces a forward pulse carrying the owner, the block and an exclusive flag that is 1 for GETX.
- R4: A NACK answer (answer code 0) to a forward produces, one cycle later, a completion to the original requester with NACK (code 4). The entry is left unchanged, so a retry is forwarded to the same processor again.
- R5: A CLEAN (answer code 1) or DATA (answer code 2) answer produces a completion one cycle later. For a GETS it carries GRANT_S and the block becomes shared by the requester, plus the old owner on DATA. For a GETX it carries GRANT_M and the requester becomes the owner.
- R6: A transaction-end strobe clears that processor's overflow bit one cycle later. Sticky entries are not touched and are still forwarded on their next access.
- R7: While a forward is outstanding, a request to the same block, or any request that would need a forward, is answered with BUSY (code 5) and changes nothing. Requests to other blocks that need no forward are served normally.
- R8: A PUTX without the transaction flag from the owner of a modified block is acknowledged and invalidates the entry. A PUTX from any processor that does not own the block in the modified state is acknowledged and changes no entry and no overflow bit.
- R9: When a transaction end and a transactional PUTX for the same processor arrive in the same cycle, that processor's overflow bit ends up set.
- R10: A GETS or GETX from the processor recorded as owner of a modified or sticky block is granted directly, with no forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqProc | input | ProcW | Requesting processor |
| reqOp | input | 2 | 0 GETS, 1 GETX, 2 PUTX |
| reqBlock | input | BlkW | Target block |
| reqTxn | input | 1 | PUTX carries transactional data |
| fwdRespValid | input | 1 | Answer to the outstanding forward |
| fwdRespCode | input | 2 | 0 NACK, 1 CLEAN, 2 DATA |
| txEndValid | input | 1 | Transaction commit or abort |
| txEndProc | input | ProcW | Processor ending its transaction |
| respValid | output | 1 | Immediate response strobe |
| respProc | output | ProcW | Processor addressed by the response |
| respCode | output | 3 | Response code |
| fwdValid | output | 1 | Forward strobe |
| fwdProc | output | ProcW | Processor receiving the forward |
| fwdBlock | output | BlkW | Forwarded block |
| fwdExcl | output | 1 | Forward is for an exclusive request |
| doneValid | output | 1 | Completion of a forwarded request |
| doneProc | output | ProcW | Original requester |
| doneCode | output | 3 | Completion code |
| ovfBits | output | NumProcs | Per-processor overflow bits |

## Verification
The hardest state to reach is a sticky entry that must survive the end of its transaction. The overflow bit is cleared while the entry still points at the old holder, and only the next access shows whether the entry was cleaned. The stimulus builds this state step by step. It evicts a block with the transaction flag and sends a conflicting read, which the holder refuses. It then ends the transaction and retries. The bench checks that the retry is still forwarded, and that only the CLEAN answer turns the entry into a plain shared block that a third processor can then take without a forward. Busy turn-aways are provoked by issuing requests while a forward is left unanswered on purpose.

// File: rtl/dir_pkg.sv
package dir_pkg;
  localparam int NumProcs  = 4;
  localparam int NumBlocks = 4;
  localparam int ProcW = (NumProcs > 1) ? $clog2(NumProcs) : 1;
  localparam int BlkW  = (NumBlocks > 1) ? $clog2(NumBlocks) : 1;

  typedef logic [ProcW-1:0]    procId_t;
  typedef logic [BlkW-1:0]     blkId_t;
  typedef logic [NumProcs-1:0] sharers_t;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2, ST_SM = 2'd3} dirState_e;

  localparam logic [1:0] OP_GETS = 2'd0;
  localparam logic [1:0] OP_GETX = 2'd1;
  localparam logic [1:0] OP_PUTX = 2'd2;

  localparam logic [2:0] RSP_GRANT_S = 3'd1;
  localparam logic [2:0] RSP_GRANT_M = 3'd2;
  localparam logic [2:0] RSP_ACK     = 3'd3;
  localparam logic [2:0] RSP_NACK    = 3'd4;
  localparam logic [2:0] RSP_BUSY    = 3'd5;

  localparam logic [1:0] ANS_NACK  = 2'd0;
  localparam logic [1:0] ANS_CLEAN = 2'd1;
  localparam logic [1:0] ANS_DATA  = 2'd2;

  typedef struct packed {
    dirState_e state;
    procId_t   owner;
    sharers_t  sharers;
  } dirEntry_t;

  typedef struct packed {
    logic       reqWr;
    dirEntry_t  reqEntry;
    logic       pendWr;
    dirEntry_t  pendEntry;
    logic       setOvf;
    logic       startFwd;
    procId_t    fwdTo;
    logic       endPend;
    logic       respValid;
    logic [2:0] respCode;
    logic       doneValid;
    logic [2:0] doneCode;
  } dirStrobes_t;
endpackage

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic        reqValid,
  input  procId_t     reqProc,
  input  logic [1:0]  reqOp,
  input  blkId_t      reqBlock,
  input  logic        reqTxn,
  input  dirEntry_t   curEntry,
  input  logic        pendValid,
  input  blkId_t      pendBlock,
  input  procId_t     pendProc,
  input  logic [1:0]  pendOp,
  input  dirEntry_t   pendEntry,
  input  logic        fwdRespValid,
  input  logic [1:0]  fwdRespCode,
  output dirStrobes_t stb
);
  logic blocked, isOwned, ownerHit;
  sharers_t reqBit, pendBit, oldOwnerBit;

  assign blocked     = pendValid && (pendBlock == reqBlock);
  assign isOwned     = (curEntry.state == ST_M) || (curEntry.state == ST_SM);
  assign ownerHit    = isOwned && (curEntry.owner == reqProc);
  assign reqBit      = sharers_t'(1) << reqProc;
  assign pendBit     = sharers_t'(1) << pendProc;
  assign oldOwnerBit = sharers_t'(1) << pendEntry.owner;

  always_comb begin
    stb = '0;
    stb.reqEntry  = curEntry;
    stb.pendEntry = pendEntry;
    stb.fwdTo     = curEntry.owner;
    if (reqValid) begin
      if (blocked) begin
        stb.respValid = 1'b1;
        stb.respCode  = RSP_BUSY;
      end else if (reqOp == OP_GETS || reqOp == OP_GETX) begin
        if (isOwned && !ownerHit) begin
          if (pendValid) begin
            stb.respValid = 1'b1;
            stb.respCode  = RSP_BUSY;
          end else begin
            stb.startFwd = 1'b1;
          end
        end else begin
          stb.respValid = 1'b1;
          stb.reqWr     = 1'b1;
          if (reqOp == OP_GETS) begin
            stb.respCode         = RSP_GRANT_S;
            stb.reqEntry.state   = ST_S;
            stb.reqEntry.sharers = ((curEntry.state == ST_S) ? curEntry.sharers : '0) | reqBit;
          end else begin
            stb.respCode         = RSP_GRANT_M;
            stb.reqEntry.state   = ST_M;
            stb.reqEntry.owner   = reqProc;
            stb.reqEntry.sharers = '0;
          end
        end
      end else if (reqOp == OP_PUTX) begin
        stb.respValid = 1'b1;
        stb.respCode  = RSP_ACK;
        if (ownerHit && curEntry.state == ST_M) begin
          stb.reqWr = 1'b1;
          if (reqTxn) begin
            stb.reqEntry.state = ST_SM;
            stb.setOvf         = 1'b1;
          end else begin
            stb.reqEntry.state   = ST_I;
            stb.reqEntry.sharers = '0;
          end
        end
      end
    end

    if (pendValid && fwdRespValid) begin
      stb.endPend   = 1'b1;
      stb.doneValid = 1'b1;
      if (fwdRespCode == ANS_NACK) begin
        stb.doneCode = RSP_NACK;
      end else begin
        stb.pendWr = 1'b1;
        if (pendOp == OP_GETX) begin
          stb.doneCode          = RSP_GRANT_M;
          stb.pendEntry.state   = ST_M;
          stb.pendEntry.owner   = pendProc;
          stb.pendEntry.sharers = '0;
        end else begin
          stb.doneCode          = RSP_GRANT_S;
          stb.pendEntry.state   = ST_S;
          stb.pendEntry.sharers = pendBit | ((fwdRespCode == ANS_DATA) ? oldOwnerBit : '0);
        end
      end
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dirStrobes_t stb,
  input  procId_t     reqProc,
  input  logic [1:0]  reqOp,
  input  blkId_t      reqBlock,
  input  logic        txEndValid,
  input  procId_t     txEndProc,
  output dirEntry_t   curEntry,
  output dirEntry_t   pendEntry,
  output logic        pendValid,
  output blkId_t      pendBlock,
  output procId_t     pendProc,
  output logic [1:0]  pendOp,
  output sharers_t    ovfBits,
  output logic        respValid,
  output procId_t     respProc,
  output logic [2:0]  respCode,
  output logic        fwdValid,
  output procId_t     fwdProc,
  output blkId_t      fwdBlock,
  output logic        fwdExcl,
  output logic        doneValid,
  output procId_t     doneProc,
  output logic [2:0]  doneCode
);
  dirEntry_t entries [NumBlocks];
  sharers_t  ovfNext;

  assign curEntry  = entries[reqBlock];
  assign pendEntry = entries[pendBlock];

  always_comb begin
    ovfNext = ovfBits;
    if (txEndValid) ovfNext[txEndProc] = 1'b0;
    if (stb.setOvf) ovfNext[reqProc]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NumBlocks; i++) entries[i] <= '0;
      ovfBits   <= '0;
      pendValid <= 1'b0;
      pendBlock <= '0;
      pendProc  <= '0;
      pendOp    <= '0;
      respValid <= 1'b0;
      respProc  <= '0;
      respCode  <= '0;
      fwdValid  <= 1'b0;
      fwdProc   <= '0;
      fwdBlock  <= '0;
      fwdExcl   <= 1'b0;
      doneValid <= 1'b0;
      doneProc  <= '0;
      doneCode  <= '0;
    end else begin
      if (stb.reqWr)  entries[reqBlock]  <= stb.reqEntry;
      if (stb.pendWr) entries[pendBlock] <= stb.pendEntry;
      ovfBits <= ovfNext;
      if (stb.startFwd) begin
        pendValid <= 1'b1;
        pendBlock <= reqBlock;
        pendProc  <= reqProc;
        pendOp    <= reqOp;
      end else if (stb.endPend) begin
        pendValid <= 1'b0;
      end
      respValid <= stb.respValid;
      respProc  <= reqProc;
      respCode  <= stb.respCode;
      fwdValid  <= stb.startFwd;
      fwdProc   <= stb.fwdTo;
      fwdBlock  <= reqBlock;
      fwdExcl   <= (reqOp == OP_GETX);
      doneValid <= stb.doneValid;
      doneProc  <= pendProc;
      doneCode  <= stb.doneCode;
    end
  end
endmodule

// File: rtl/dir_top.sv
module dir_top
  import dir_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ProcW-1:0]    reqProc,
  input  logic [1:0]          reqOp,
  input  logic [BlkW-1:0]     reqBlock,
  input  logic                reqTxn,
  input  logic                fwdRespValid,
  input  logic [1:0]          fwdRespCode,
  input  logic                txEndValid,
  input  logic [ProcW-1:0]    txEndProc,
  output logic                respValid,
  output logic [ProcW-1:0]    respProc,
  output logic [2:0]          respCode,
  output logic                fwdValid,
  output logic [ProcW-1:0]    fwdProc,
  output logic [BlkW-1:0]     fwdBlock,
  output logic                fwdExcl,
  output logic                doneValid,
  output logic [ProcW-1:0]    doneProc,
  output logic [2:0]          doneCode,
  output logic [NumProcs-1:0] ovfBits
);
  dirStrobes_t stb;
  dirEntry_t   curEntry, pendEntry;
  logic        pendValid;
  blkId_t      pendBlock;
  procId_t     pendProc;
  logic [1:0]  pendOp;

  dir_ctrl u_ctrl (
    .reqValid(reqValid), .reqProc(reqProc), .reqOp(reqOp), .reqBlock(reqBlock),
    .reqTxn(reqTxn), .curEntry(curEntry), .pendValid(pendValid),
    .pendBlock(pendBlock), .pendProc(pendProc), .pendOp(pendOp),
    .pendEntry(pendEntry), .fwdRespValid(fwdRespValid),
    .fwdRespCode(fwdRespCode), .stb(stb)
  );

  dir_store u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .reqProc(reqProc), .reqOp(reqOp),
    .reqBlock(reqBlock), .txEndValid(txEndValid), .txEndProc(txEndProc),
    .curEntry(curEntry), .pendEntry(pendEntry), .pendValid(pendValid),
    .pendBlock(pendBlock), .pendProc(pendProc), .pendOp(pendOp),
    .ovfBits(ovfBits), .respValid(respValid), .respProc(respProc),
    .respCode(respCode), .fwdValid(fwdValid), .fwdProc(fwdProc),
    .fwdBlock(fwdBlock), .fwdExcl(fwdExcl), .doneValid(doneValid),
    .doneProc(doneProc), .doneCode(doneCode)
  );
endmodule

// File: rtl/dir_checker.sv
module dir_checker
  import dir_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input procId_t    reqProc,
  input logic [1:0] reqOp,
  input blkId_t     reqBlock,
  input logic       reqTxn,
  input logic       fwdRespValid,
  input logic       txEndValid,
  input procId_t    txEndProc,
  input logic       respValid,
  input logic [2:0] respCode,
  input logic       fwdValid,
  input logic       doneValid,
  input sharers_t   ovfBits,
  input logic       pendValid,
  input blkId_t     pendBlock
);
  // R2: an overflow bit only rises after a transactional writeback
  p_ovf_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfBits & ~$past(ovfBits)) != '0) |-> $past(reqValid && reqOp == OP_PUTX && reqTxn));

  // R3: a forward goes out with no immediate response and opens a pending slot
  p_fwd_no_resp_r3: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (!respValid && pendValid));

  // R4: a completion only follows an answer to an outstanding forward
  p_done_after_answer_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(pendValid && fwdRespValid));

  // R6: transaction end clears the bit unless a same-processor transactional writeback coincides
  p_ovf_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txEndValid && !(reqValid && reqOp == OP_PUTX && reqTxn && reqProc == txEndProc))
      |=> !ovfBits[$past(txEndProc)]);

  // R7: a request to the locked block is turned away as busy
  p_busy_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pendValid && reqBlock == pendBlock) |=> (respValid && respCode == RSP_BUSY));
endmodule

bind dir_top dir_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqProc(reqProc), .reqOp(reqOp),
  .reqBlock(reqBlock), .reqTxn(reqTxn), .fwdRespValid(fwdRespValid),
  .txEndValid(txEndValid), .txEndProc(txEndProc), .respValid(respValid),
  .respCode(respCode), .fwdValid(fwdValid), .doneValid(doneValid),
  .ovfBits(ovfBits), .pendValid(pendValid), .pendBlock(pendBlock)
);

// File: tb/sim_dir_top.sv
module sim_dir_top;
  import dir_pkg::*;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqTxn = 1'b0, fwdRespValid = 1'b0, txEndValid = 1'b0;
  procId_t reqProc = '0, txEndProc = '0;
  logic [1:0] reqOp = '0, fwdRespCode = '0;
  blkId_t reqBlock = '0;
  logic respValid, fwdValid, fwdExcl, doneValid;
  procId_t respProc, fwdProc, doneProc;
  logic [2:0] respCode, doneCode;
  blkId_t fwdBlock;
  sharers_t ovfBits;

  int checks = 0, failures = 0;
  bit finished = 0;
  int respQ[$], fwdQ[$], doneQ[$];
  string respT[$], fwdT[$], doneT[$];

  always #(ClkPeriod/2) clk = ~clk;

  dir_top u0 (.*);

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: compares every produced item with the scoreboard queues
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (respValid) begin
        if (respQ.size() == 0) check("R7 unexpected response", int'(respProc)*8 + int'(respCode), -1);
        else check(respT.pop_front(), int'(respProc)*8 + int'(respCode), respQ.pop_front());
      end
      if (fwdValid) begin
        if (fwdQ.size() == 0) check("R3 unexpected forward", int'(fwdProc)*64 + int'(fwdBlock)*2 + int'(fwdExcl), -1);
        else check(fwdT.pop_front(), int'(fwdProc)*64 + int'(fwdBlock)*2 + int'(fwdExcl), fwdQ.pop_front());
      end
      if (doneValid) begin
        if (doneQ.size() == 0) check("R4 unexpected completion", int'(doneProc)*8 + int'(doneCode), -1);
        else check(doneT.pop_front(), int'(doneProc)*8 + int'(doneCode), doneQ.pop_front());
      end
    end
  end

  // driver: one request; exp < 0 means no immediate response is expected
  task automatic req(int p, logic [1:0] op, int b, bit txn, int exp, string tag);
    @(negedge clk);
    reqValid = 1'b1; reqProc = procId_t'(p); reqOp = op; reqBlock = blkId_t'(b); reqTxn = txn;
    if (exp >= 0) begin respQ.push_back(p*8 + exp); respT.push_back(tag); end
    @(negedge clk);
    reqValid = 1'b0; reqTxn = 1'b0;
  endtask

  task automatic expFwd(int p, int b, int excl, string tag);
    fwdQ.push_back(p*64 + b*2 + excl); fwdT.push_back(tag);
  endtask

  task automatic answer(logic [1:0] code, int p, int exp, string tag);
    @(negedge clk);
    fwdRespValid = 1'b1; fwdRespCode = code;
    doneQ.push_back(p*8 + exp); doneT.push_back(tag);
    @(negedge clk);
    fwdRespValid = 1'b0;
  endtask

  task automatic txEnd(int p);
    @(negedge clk);
    txEndValid = 1'b1; txEndProc = procId_t'(p);
    @(negedge clk);
    txEndValid = 1'b0;
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(ClkPeriod * 100000);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset respValid", respValid, 0);
    check("R1 reset fwdValid", fwdValid, 0);
    check("R1 reset doneValid", doneValid, 0);
    check("R1 reset ovfBits", ovfBits, 0);
    rstN = 1'b1;

    req(0, OP_GETX, 0, 0, RSP_GRANT_M, "R1 GETX invalid");
    req(1, OP_GETS, 1, 0, RSP_GRANT_S, "R1 GETS invalid");
    req(2, OP_GETS, 1, 0, RSP_GRANT_S, "R1 GETS shared");
    req(3, OP_GETX, 1, 0, RSP_GRANT_M, "R1 GETX shared");

    req(0, OP_PUTX, 0, 1, RSP_ACK, "R2 transactional writeback ack");
    check("R2 overflow bit set", ovfBits, 4'b0001);

    expFwd(0, 0, 0, "R3 forward to sticky holder");
    req(1, OP_GETS, 0, 0, -1, "R3");

    req(2, OP_GETX, 0, 0, RSP_BUSY, "R7 locked block busy");
    req(2, OP_GETS, 1, 0, RSP_BUSY, "R7 second forward busy");
    req(3, OP_GETS, 2, 0, RSP_GRANT_S, "R7 other block served");

    answer(ANS_NACK, 1, RSP_NACK, "R4 nack completion");

    txEnd(0);
    check("R6 overflow cleared", ovfBits, 4'b0000);

    expFwd(0, 0, 0, "R6 sticky still forwarded after end R4");
    req(1, OP_GETS, 0, 0, -1, "R6");
    answer(ANS_CLEAN, 1, RSP_GRANT_S, "R5 clean completion");
    req(2, OP_GETX, 0, 0, RSP_GRANT_M, "R5 cleaned entry granted directly");

    expFwd(3, 1, 1, "R3 exclusive forward to owner");
    req(0, OP_GETX, 1, 0, -1, "R3");
    answer(ANS_DATA, 0, RSP_GRANT_M, "R5 data completion exclusive");
    expFwd(0, 1, 0, "R5 new owner recorded");
    req(3, OP_GETS, 1, 0, -1, "R5");
    answer(ANS_DATA, 3, RSP_GRANT_S, "R5 data completion shared");
    req(1, OP_GETS, 1, 0, RSP_GRANT_S, "R5 entry now shared");

    req(2, OP_PUTX, 0, 0, RSP_ACK, "R8 plain writeback ack");
    check("R8 plain writeback no overflow", ovfBits, 4'b0000);
    req(1, OP_GETS, 0, 0, RSP_GRANT_S, "R8 entry invalidated");

    req(1, OP_GETX, 2, 0, RSP_GRANT_M, "R1 GETX shared block2");
    req(0, OP_PUTX, 2, 1, RSP_ACK, "R8 non-owner writeback ack");
    check("R8 non-owner no overflow", ovfBits, 4'b0000);
    expFwd(1, 2, 0, "R8 owner unchanged after non-owner writeback");
    req(3, OP_GETS, 2, 0, -1, "R8");
    answer(ANS_CLEAN, 3, RSP_GRANT_S, "R5 clean on owned");

    req(2, OP_GETX, 3, 0, RSP_GRANT_M, "R1 GETX block3");
    @(negedge clk);
    reqValid = 1'b1; reqProc = 2; reqOp = OP_PUTX; reqBlock = 3; reqTxn = 1'b1;
    txEndValid = 1'b1; txEndProc = 2;
    respQ.push_back(2*8 + RSP_ACK); respT.push_back("R9 ack");
    @(negedge clk);
    reqValid = 1'b0; reqTxn = 1'b0; txEndValid = 1'b0;
    check("R9 set wins over clear", ovfBits, 4'b0100);

    req(2, OP_GETS, 3, 0, RSP_GRANT_S, "R10 sticky owner direct grant");

    repeat (4) @(negedge clk);
    check("R3 forward queue drained", fwdQ.size(), 0);
    check("R4 completion queue drained", doneQ.size(), 0);
    check("R1 response queue drained", respQ.size(), 0);
    finish();
  end
endmodule